// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block collects a serial bit stream into a chain of shift stages and, on a separate strobe, copies the whole chain into a holding register that drives a parallel bus. Both the shift stages and the holding register have their own clock, so a new word can be shifted in while the previous word stays stable on the outputs. The last stage is exported as a cascade bit, so several instances can be chained into a longer register by feeding each cascade bit into the next serial input.

An active-low clear empties the shift stages at once, without waiting for a clock edge, and leaves the holding register as it was. An active-low enable gates the parallel bus. Instead of a tri-state driver the block gives a drive flag beside the data bus, and the pad-level buffer is left to the chip top. When the bus is disabled, the data lines read zero.

Top module: `latched_shreg`

## Requirements
- R1: On each rising edge of `shift_clk` with `clr_n` high, `ser_in` is captured into stage 0 and every stage i moves to stage i+1.
- R2: `ser_out` always equals the last stage (stage 7 by default). After a shift it shows what stage 6 held before that shift.
- R3: On each rising edge of `store_clk`, all stages are copied in parallel into the holding register. `par_out` bit i corresponds to stage i.
- R4: `clr_n` low clears every stage, and with them `ser_out`, to 0 at once without a clock. It leaves the holding register unchanged.
- R5: A `store_clk` edge while `clr_n` is low loads all zeros into the holding register.
- R6: While `oe_n` is low, `par_out` shows the holding register and `par_drive` is 1. While `oe_n` is high, `par_out` is all zeros and `par_drive` is 0. `oe_n` never changes the stages, the holding register or `ser_out`.
- R7: When `shift_clk` and `store_clk` rise together, the holding register takes the stage contents from before that edge, so it stays one shift behind.
- R8: After `clr_n` returns high, shifting resumes from an all-zero chain.
- R9: With two instances chained (`ser_out` of the first into `ser_in` of the second), a 16-bit word shifted most significant bit first ends with bit i in overall stage i. The low byte appears on the first instance and the high byte on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, active on the rising edge |
| store_clk | input | 1 | Holding register clock, active on the rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel bus enable, active low |
| ser_in | input | 1 | Serial data input |
| par_out | output | STAGES | Parallel data from the holding register, zero when disabled |
| par_drive | output | 1 | High when the parallel bus should be driven |
| ser_out | output | 1 | Cascade bit, the last stage |

## Verification
Two chained instances are driven against a 16-bit behavioural model, with a check on every clock. The stimulus first runs a walking one and a fixed word. The walking one shows whether stages are skipped or reordered, and the fixed word shows whether the byte order across the chain is right. Shifting with both clocks tied shows whether the holding register is one shift behind or takes the same edge. A clear pulsed in the middle of a stream shows whether the clear leaks into the holding register. Enable toggling during shifting shows whether the gate is applied only at the outputs. A long pseudo-random run, with independent shift, store and enable choices, mixes all of these.

// File: rtl/latched_shreg.sv
module latched_shreg #(
  parameter int STAGES = 8
) (
  input  logic              shift_clk,
  input  logic              store_clk,
  input  logic              clr_n,
  input  logic              oe_n,
  input  logic              ser_in,
  output logic [STAGES-1:0] par_out,
  output logic              par_drive,
  output logic              ser_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh_q;
  logic [LAST:0] hold_q;
  logic          sh_seen;

  always_ff @(posedge shift_clk or negedge clr_n)
    if (!clr_n) sh_q <= '0;
    else        sh_q <= {sh_q[LAST-1:0], ser_in};

  always_ff @(posedge shift_clk or negedge clr_n)
    if (!clr_n) sh_seen <= 1'b0;
    else        sh_seen <= 1'b1;

  always_ff @(posedge store_clk)
    hold_q <= sh_q;

  assign ser_out   = sh_q[LAST];
  assign par_drive = ~oe_n;
  assign par_out   = oe_n ? '0 : hold_q;

  AST_STAGE0_CAPTURE: assert property (@(posedge shift_clk) disable iff (!clr_n)
    sh_seen |-> sh_q[0] == $past(ser_in)); // R1

  AST_CASCADE_TAIL: assert property (@(posedge shift_clk) disable iff (!clr_n)
    sh_seen |-> ser_out == $past(sh_q[LAST-1])); // R2

  AST_CLEAR_EMPTY: assert property (@(posedge shift_clk) disable iff (!clr_n)
    !sh_seen |-> (sh_q == '0 && !ser_out)); // R4

  AST_HOLD_COPY: assert property (@(posedge store_clk) disable iff (!clr_n)
    1'b1 |=> hold_q == $past(sh_q)); // R3

  always_comb
    if (par_drive) AST_BUS_SHOWS_HOLD: assert (par_out == hold_q); // R6
endmodule

// File: tb/test_latched_shreg.sv
module test_latched_shreg;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic sh_gate = 1'b0, st_gate = 1'b0;
  logic clr_n = 1'b0, oe_n = 1'b1, din = 1'b0;
  wire  shift_clk = clk & sh_gate;
  wire  store_clk = clk & st_gate;

  logic [7:0] par_lo, par_hi;
  logic drv_lo, drv_hi, ser_lo, ser_hi;

  latched_shreg i_latched_shreg (
    .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
    .ser_in(din), .par_out(par_lo), .par_drive(drv_lo), .ser_out(ser_lo));

  latched_shreg i_latched_shreg_hi (
    .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
    .ser_in(ser_lo), .par_out(par_hi), .par_drive(drv_hi), .ser_out(ser_hi));

  logic [15:0] m_sh = '0, m_st = '0;
  int vectors = 0, fails = 0, cycles = 0;
  bit cmp_on = 1'b0;
  string tag = "R5";

  always @(posedge clk) begin
    cycles++;
    if (!clr_n) m_sh = '0;
    if (st_gate) m_st = m_sh;
    if (sh_gate && clr_n) m_sh = {m_sh[14:0], din};
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (cmp_on) begin
      chk({tag, " parallel"}, {par_hi, par_lo}, oe_n ? 16'h0 : m_st);
      chk({tag, " drive"}, {14'h0, drv_hi, drv_lo}, oe_n ? 16'h0 : 16'h3);
      chk({tag, " cascade"}, {14'h0, ser_hi, ser_lo}, {14'h0, m_sh[15], m_sh[7]});
    end
  endtask

  task automatic step(input bit sh, input bit st, input bit d, input bit cl, input bit oe);
    @(negedge clk);
    compare();
    sh_gate = sh; st_gate = st; din = d; clr_n = cl; oe_n = oe;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] word;

  initial begin
    step(0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    cmp_on = 1'b1;
    step(0, 0, 0, 1, 0);
    chk("R5 zero load in clear", {par_hi, par_lo}, 16'h0);
    chk("R4 cascade cleared", {14'h0, ser_hi, ser_lo}, 16'h0);

    tag = "R1";
    step(1, 0, 1, 1, 0);
    for (int i = 0; i < 15; i++) step(1, 0, 0, 1, 0);
    step(0, 1, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    chk("R3 walking one in last stage", {par_hi, par_lo}, 16'h8000);
    chk("R2 cascade holds walking one", {15'h0, ser_hi}, 16'h1);

    tag = "R9";
    word = 16'hA53C;
    for (int i = 15; i >= 0; i--) step(1, 0, word[i], 1, 0);
    step(0, 1, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    chk("R9 chained word order", {par_hi, par_lo}, word);

    tag = "R7";
    for (int i = 0; i < 20; i++) step(1, 1, i[0] ^ i[2], 1, 0);
    step(0, 0, 0, 1, 0);

    tag = "R4";
    word = {par_hi, par_lo};
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R4 clear keeps hold", {par_hi, par_lo}, word);
    chk("R4 clear empties cascade", {14'h0, ser_hi, ser_lo}, 16'h0);
    tag = "R8";
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    step(0, 1, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    chk("R8 resume from zeros", {par_hi, par_lo}, 16'h0003);

    tag = "R6";
    for (int i = 0; i < 24; i++) step(1, i % 5 == 0, i[1], 1, i[0]);
    step(0, 0, 0, 1, 1);
    chk("R6 disabled bus reads zero", {par_hi, par_lo}, 16'h0);
    chk("R6 disabled drive flag", {14'h0, drv_hi, drv_lo}, 16'h0);
    step(0, 0, 0, 1, 0);

    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[3] & lfsr[7], lfsr[9], !(lfsr[2] & lfsr[4] & lfsr[6] & lfsr[8]), lfsr[11] & lfsr[1]);
    end
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule